// File: doc/BRIEF.md
# Single-Precision Float to 32-bit Integer Converter

This block turns a packed IEEE-754 binary32 word into a 32-bit integer, either unsigned or two's-complement signed, under one of four rounding modes. Along with the integer it reports three flags: invalid (the value does not fit, or is NaN), inexact (fraction bits were dropped), and input-denormal (the source was a subnormal).

The conversion is combinational. A single register stage sits at the output, so a value presented on one clock shows up on the outputs after the next rising edge. A force-truncate input overrides the rounding-mode input. This suits the case where a caller needs C-style truncation without rewriting the mode field.

Inputs whose magnitude is below one half take a short path of their own. Inputs whose exponent puts them beyond the 32-bit range saturate at once. Everything between goes through a shifter that splits the value into an integer part and a 32-bit fraction word, followed by a mode-dependent rounding carry.

Top module: `fp32_to_int`

## Requirements
- R1: All four outputs are registered. They reflect the inputs sampled at the previous rising clock edge, and they read as zero while the active-low asynchronous reset is held.
- R2: The rounding-mode input encodes 2'b00 as nearest with ties to even, 2'b01 as toward +infinity, 2'b10 as toward -infinity and 2'b11 as toward zero. When the force-truncate input is high, toward-zero is used whatever the mode input says.
- R3: The denormal flag is set exactly when the biased exponent (bits 30:23) is zero and the fraction (bits 22:0) is nonzero. Such an input is always inexact.
- R4: Positive and negative zero both give 0 with all three flags clear.
- R5: A biased exponent of 159 or more (this includes infinities and NaNs) raises invalid and nothing else. Unsigned gives 0 for a negative sign (bit 31) and 0xFFFFFFFF otherwise, with any NaN treated as positive. Signed gives 0x7FFFFFFF for positive and 0x80000000 for negative, NaN included.
- R6: For biased exponents 126 to 158, the magnitude is rounded to an integer in the selected mode. Inexact is raised when any discarded fraction bit is set and the result is not invalid.
- R7: Unsigned with a negative sign: a nonzero rounded magnitude gives 0 with invalid and without inexact. A zero rounded magnitude gives 0, inexact only if fraction bits were dropped.
- R8: Signed: the rounded magnitude may reach 0x7FFFFFFF for positive inputs and 0x80000000 for negative inputs. Beyond that the result clamps to that limit with invalid and without inexact. Negative results are two's complement.
- R9: A nonzero input with biased exponent below 126 gives 0 with inexact. The exceptions are toward +infinity on a positive input, which gives 1, and toward -infinity on a negative input, which gives 0xFFFFFFFF signed, or 0 with invalid and inexact unsigned.
- R10: At biased exponent 126 (magnitudes in [0.5, 1)), nearest mode gives 0 for exactly one half and 1 above one half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fp_in | input | 32 | Packed binary32 operand |
| signed_sel | input | 1 | 1 selects a signed result, 0 an unsigned one |
| rnd_mode | input | 2 | Rounding mode, encoded as in R2 |
| trunc_force | input | 1 | Forces rounding toward zero |
| int_out | output | 32 | Converted integer, registered |
| invalid_o | output | 1 | Invalid-operation flag, registered |
| inexact_o | output | 1 | Inexact flag, registered |
| denorm_o | output | 1 | Denormal-input flag, registered |

## Verification
All results and all three flags are due exactly one rising edge after the operand and controls are applied. The bench changes inputs only on a falling edge. It compares the outputs on the following falling edge against a value it computed from the same inputs at the moment they were driven. The reference rounds by comparing the exact fraction against one half in 64-bit fixed point, not by reproducing the increment-and-carry method. The reset value is checked while reset is still asserted, before any operand is applied.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;

  localparam int FLT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int BIAS   = 127;
  localparam int INT_W  = 32;
  localparam int PAD_W  = INT_W - 2 - MAN_W;
  localparam int SH_W   = $clog2(INT_W + 1);

  // exponent thresholds for the three numeric paths
  localparam logic [EXP_W-1:0] SAT_EXP  = EXP_W'(BIAS + INT_W);
  localparam logic [EXP_W-1:0] TOP_EXP  = EXP_W'(BIAS + INT_W - 1);
  localparam logic [EXP_W-1:0] HALF_EXP = EXP_W'(BIAS - 1);

  localparam logic [INT_W-1:0] U_MAX = {INT_W{1'b1}};
  localparam logic [INT_W-1:0] S_MAX = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN = {1'b1, {(INT_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    RG_ZERO = 2'b00,
    RG_TINY = 2'b01,
    RG_MID  = 2'b10,
    RG_SAT  = 2'b11
  } range_e;

  typedef struct packed {
    logic              neg;
    logic [EXP_W-1:0]  bexp;
    logic [INT_W-1:0]  sig;
    range_e            rng;
    logic              denorm;
    logic              nan;
  } fclass_t;

endpackage

// File: rtl/fp2i_unpack.sv
module fp2i_unpack
  import fp2i_pkg::*;
(
  input  logic [FLT_W-1:0] fp_i,
  output fclass_t          cls_o
);

  logic [EXP_W-1:0] bexp;
  logic [MAN_W-1:0] frac;
  logic             exp_zero;
  logic             exp_ones;
  logic             frac_nz;
  logic             hidden;

  always_comb begin
    bexp     = fp_i[FLT_W-2 -: EXP_W];
    frac     = fp_i[MAN_W-1:0];
    exp_zero = (bexp == '0);
    exp_ones = (bexp == {EXP_W{1'b1}});
    frac_nz  = (frac != '0);
    hidden   = !exp_zero;

    cls_o.neg    = fp_i[FLT_W-1];
    cls_o.bexp   = bexp;
    // hidden bit sits one below the top bit of the word
    cls_o.sig    = {1'b0, hidden, frac, {PAD_W{1'b0}}};
    cls_o.denorm = exp_zero && frac_nz;
    cls_o.nan    = exp_ones && frac_nz;

    if (exp_zero && !frac_nz)
      cls_o.rng = RG_ZERO;
    else if (bexp >= SAT_EXP)
      cls_o.rng = RG_SAT;
    else if (bexp >= HALF_EXP)
      cls_o.rng = RG_MID;
    else
      cls_o.rng = RG_TINY;
  end

endmodule

// File: rtl/fp2i_align.sv
module fp2i_align
  import fp2i_pkg::*;
(
  input  logic [INT_W-1:0] sig_i,
  input  logic [EXP_W-1:0] bexp_i,
  input  logic             neg_i,
  input  rmode_e           rm_i,
  output logic [INT_W-1:0] ipart_o,
  output logic [INT_W-1:0] rem_o,
  output logic             bump_o
);

  logic [EXP_W-1:0]    sh_full;
  logic [SH_W-1:0]     sh;
  logic [2*INT_W-1:0]  seed;
  logic [2*INT_W-1:0]  wide;
  logic [INT_W-1:0]    incr;
  logic [INT_W-1:0]    rsum;

  always_comb begin
    // only meaningful on the mid path, where it spans 0..INT_W
    sh_full = TOP_EXP - bexp_i;
    sh      = sh_full[SH_W-1:0];
    seed    = {sig_i, {INT_W{1'b0}}};
    wide    = (seed << 1) >> sh;
    ipart_o = wide[2*INT_W-1:INT_W];
    rem_o   = wide[INT_W-1:0];

    unique case (rm_i)
      RM_NEAR: incr = S_MIN - {{(INT_W-1){1'b0}}, !ipart_o[0]};
      RM_ZERO: incr = '0;
      default: incr = ((rm_i == RM_UP) ^ neg_i) ? U_MAX : '0;
    endcase

    rsum   = rem_o + incr;
    bump_o = (rsum < rem_o);
  end

endmodule

// File: rtl/fp2i_saturate.sv
module fp2i_saturate
  import fp2i_pkg::*;
(
  input  range_e           rng_i,
  input  logic             neg_i,
  input  logic             nan_i,
  input  logic             signed_i,
  input  rmode_e           rm_i,
  input  logic [INT_W-1:0] ipart_i,
  input  logic [INT_W-1:0] rem_i,
  input  logic             bump_i,
  output logic [INT_W-1:0] res_o,
  output logic             inv_o,
  output logic             inx_o
);

  logic [INT_W-1:0] mag;
  logic [INT_W-1:0] lim;
  logic             rem_nz;

  always_comb begin
    res_o  = '0;
    inv_o  = 1'b0;
    inx_o  = 1'b0;
    mag    = ipart_i;
    lim    = neg_i ? S_MIN : S_MAX;
    rem_nz = (rem_i != '0);

    unique case (rng_i)
      RG_ZERO: begin
        res_o = '0;
      end

      RG_SAT: begin
        inv_o = 1'b1;
        if (signed_i)
          res_o = neg_i ? S_MIN : S_MAX;
        else
          res_o = (neg_i && !nan_i) ? '0 : U_MAX;
      end

      RG_MID: begin
        if (signed_i) begin
          if (bump_i && (ipart_i != U_MAX))
            mag = ipart_i + INT_W'(1);
          if (mag > lim) begin
            mag   = lim;
            inv_o = 1'b1;
          end else begin
            inx_o = rem_nz;
          end
          res_o = neg_i ? (~mag + INT_W'(1)) : mag;
        end else begin
          if (bump_i) begin
            if (ipart_i != U_MAX)
              mag = ipart_i + INT_W'(1);
            else
              inv_o = 1'b1;
          end
          if ((mag != '0) && neg_i) begin
            res_o = '0;
            inv_o = 1'b1;
          end else begin
            res_o = mag;
            inx_o = rem_nz;
          end
        end
      end

      default: begin
        inx_o = 1'b1;
        if ((rm_i == RM_UP) && !neg_i)
          res_o = INT_W'(1);
        else if ((rm_i == RM_DOWN) && neg_i) begin
          if (signed_i)
            res_o = U_MAX;
          else
            inv_o = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/fp32_to_int.sv
module fp32_to_int
  import fp2i_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FLT_W-1:0] fp_in,
  input  logic             signed_sel,
  input  logic [1:0]       rnd_mode,
  input  logic             trunc_force,
  output logic [INT_W-1:0] int_out,
  output logic             invalid_o,
  output logic             inexact_o,
  output logic             denorm_o
);

  fclass_t          cls;
  rmode_e           rm_eff;
  logic [INT_W-1:0] ipart;
  logic [INT_W-1:0] rem;
  logic             bump;
  logic [INT_W-1:0] res_nx;
  logic             inv_nx;
  logic             inx_nx;
  logic             den_nx;

  always_comb begin
    rm_eff = trunc_force ? RM_ZERO : rmode_e'(rnd_mode);
    den_nx = cls.denorm;
  end

  fp2i_unpack u_unpack (
    .fp_i  (fp_in),
    .cls_o (cls)
  );

  fp2i_align u_align (
    .sig_i   (cls.sig),
    .bexp_i  (cls.bexp),
    .neg_i   (cls.neg),
    .rm_i    (rm_eff),
    .ipart_o (ipart),
    .rem_o   (rem),
    .bump_o  (bump)
  );

  fp2i_saturate u_sat (
    .rng_i    (cls.rng),
    .neg_i    (cls.neg),
    .nan_i    (cls.nan),
    .signed_i (signed_sel),
    .rm_i     (rm_eff),
    .ipart_i  (ipart),
    .rem_i    (rem),
    .bump_i   (bump),
    .res_o    (res_nx),
    .inv_o    (inv_nx),
    .inx_o    (inx_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_out   <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
      denorm_o  <= 1'b0;
    end else begin
      int_out   <= res_nx;
      invalid_o <= inv_nx;
      inexact_o <= inx_nx;
      denorm_o  <= den_nx;
    end
  end

  // R3
  den_inx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    den_nx |-> inx_nx);

  // R4
  zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_in[FLT_W-2:0] == '0) |-> (res_nx == '0 && !inv_nx && !inx_nx && !den_nx));

  // R8
  s_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (signed_sel && inv_nx) |-> (res_nx == S_MAX || res_nx == S_MIN));

  // R5
  u_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!signed_sel && inv_nx) |-> (res_nx == '0 || res_nx == U_MAX));

  // R7
  u_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!signed_sel && fp_in[FLT_W-1] && !inv_nx) |-> (res_nx == '0));

endmodule

// File: tb/sim_fp32_to_int.sv
module sim_fp32_to_int;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fp_in;
  logic        signed_sel;
  logic [1:0]  rnd_mode;
  logic        trunc_force;
  logic [31:0] int_out;
  logic        invalid_o;
  logic        inexact_o;
  logic        denorm_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_to_int u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .fp_in       (fp_in),
    .signed_sel  (signed_sel),
    .rnd_mode    (rnd_mode),
    .trunc_force (trunc_force),
    .int_out     (int_out),
    .invalid_o   (invalid_o),
    .inexact_o   (inexact_o),
    .denorm_o    (denorm_o)
  );

  // result packed as {value, invalid, inexact, denormal}
  function automatic logic [34:0] ref_conv(logic [31:0] f, logic sg,
                                           logic [1:0] rmi, logic tz);
    logic              neg;
    int                e;
    logic [22:0]       fr;
    logic [1:0]        rm;
    logic [31:0]       res;
    logic              inv, inx, den, up;
    longint unsigned   q, mag, lim;
    logic [31:0]       ip, fq;
    neg = f[31];
    e   = int'(f[30:23]);
    fr  = f[22:0];
    rm  = tz ? 2'b11 : rmi;
    den = (e == 0) && (fr != 0);
    res = 0; inv = 0; inx = 0;
    if (e == 0 && fr == 0) begin
      res = 0;
    end else if (e >= 159) begin
      inv = 1;
      if (sg) res = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
      else    res = (neg && !(e == 255 && fr != 0)) ? 32'h0 : 32'hFFFF_FFFF;
    end else if (e >= 126) begin
      q  = (64'd1 << 23 | 64'(fr)) << (e - 118);
      ip = q[63:32];
      fq = q[31:0];
      case (rm)
        2'b00: up = (fq > 32'h8000_0000) || (fq == 32'h8000_0000 && ip[0]);
        2'b01: up = (fq != 0) && !neg;
        2'b10: up = (fq != 0) && neg;
        default: up = 0;
      endcase
      mag = 64'(ip) + 64'(up);
      if (!sg) begin
        if (neg && mag != 0) begin res = 0; inv = 1; end
        else begin res = mag[31:0]; inx = (fq != 0); end
      end else begin
        lim = neg ? 64'h8000_0000 : 64'h7FFF_FFFF;
        if (mag > lim) begin
          res = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
          inv = 1;
        end else begin
          inx = (fq != 0);
          res = neg ? (32'h0 - mag[31:0]) : mag[31:0];
        end
      end
    end else begin
      inx = 1;
      if (rm == 2'b01 && !neg) res = 1;
      else if (rm == 2'b10 && neg) begin
        if (sg) res = 32'hFFFF_FFFF;
        else    inv = 1;
      end
    end
    return {res, inv, inx, den};
  endfunction

  task automatic check_out(string tag, logic [34:0] expv);
    logic [34:0] act;
    act = {int_out, invalid_o, inexact_o, denorm_o};
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual val=%08h inv=%0b inx=%0b den=%0b expected val=%08h inv=%0b inx=%0b den=%0b",
               tag, act[34:3], act[2], act[1], act[0],
               expv[34:3], expv[2], expv[1], expv[0]);
    end
  endtask

  // drive on a falling edge, result is due after the next rising edge
  task automatic run(string tag, logic [31:0] f, logic sg, logic [1:0] rm, logic tz);
    logic [34:0] expv;
    @(negedge clk);
    fp_in = f; signed_sel = sg; rnd_mode = rm; trunc_force = tz;
    expv = ref_conv(f, sg, rm, tz);
    @(negedge clk);
    check_out(tag, expv);
  endtask

  task automatic run_lit(string tag, logic [31:0] f, logic sg, logic [1:0] rm,
                         logic tz, logic [34:0] lit);
    @(negedge clk);
    fp_in = f; signed_sel = sg; rnd_mode = rm; trunc_force = tz;
    @(negedge clk);
    check_out(tag, lit);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual cycles %0d expected fewer", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fp_in = 32'h3F80_0000; signed_sel = 1'b1;
    rnd_mode = 2'b00; trunc_force = 1'b0;
    repeat (3) @(negedge clk);
    check_out("R1 reset", 35'h0);
    rst_n = 1'b1;

    // literal expectations for the named corner cases
    run_lit("R4 +zero",        32'h0000_0000, 1, 2'b01, 0, {32'h0, 3'b000});
    run_lit("R4 -zero",        32'h8000_0000, 0, 2'b10, 0, {32'h0, 3'b000});
    run_lit("R3 denorm",       32'h0000_0001, 0, 2'b00, 0, {32'h0, 3'b011});
    run_lit("R3 denorm down",  32'h8040_0000, 1, 2'b10, 0, {32'hFFFF_FFFF, 3'b011});
    run_lit("R5 +inf u",       32'h7F80_0000, 0, 2'b00, 0, {32'hFFFF_FFFF, 3'b100});
    run_lit("R5 -inf u",       32'hFF80_0000, 0, 2'b00, 0, {32'h0, 3'b100});
    run_lit("R5 -nan u",       32'hFFC0_0000, 0, 2'b00, 0, {32'hFFFF_FFFF, 3'b100});
    run_lit("R5 -nan s",       32'hFFC0_0000, 1, 2'b00, 0, {32'h8000_0000, 3'b100});
    run_lit("R5 2^32 s",       32'h4F80_0000, 1, 2'b00, 0, {32'h7FFF_FFFF, 3'b100});
    run_lit("R6 2.5 near",     32'h4020_0000, 1, 2'b00, 0, {32'h2, 3'b010});
    run_lit("R6 3.5 near",     32'h4060_0000, 0, 2'b00, 0, {32'h4, 3'b010});
    run_lit("R6 2.5 up",       32'h4020_0000, 0, 2'b01, 0, {32'h3, 3'b010});
    run_lit("R6 -2.5 down",    32'hC020_0000, 1, 2'b10, 0, {32'hFFFF_FFFD, 3'b010});
    run_lit("R6 -2.5 up",      32'hC020_0000, 1, 2'b01, 0, {32'hFFFF_FFFE, 3'b010});
    run_lit("R6 1.0 exact",    32'h3F80_0000, 0, 2'b01, 0, {32'h1, 3'b000});
    run_lit("R6 top u",        32'h4F7F_FFFF, 0, 2'b00, 0, {32'hFFFF_FF00, 3'b000});
    run_lit("R2 force trunc",  32'h4060_0000, 0, 2'b01, 1, {32'h3, 3'b010});
    run_lit("R2 mode zero",    32'hC060_0000, 1, 2'b11, 0, {32'hFFFF_FFFD, 3'b010});
    run_lit("R7 -1 u",         32'hBF80_0000, 0, 2'b00, 0, {32'h0, 3'b100});
    run_lit("R7 -0.5 u",       32'hBF00_0000, 0, 2'b00, 0, {32'h0, 3'b010});
    run_lit("R7 -0.75 u",      32'hBF40_0000, 0, 2'b00, 0, {32'h0, 3'b100});
    run_lit("R8 -2^31 s",      32'hCF00_0000, 1, 2'b00, 0, {32'h8000_0000, 3'b000});
    run_lit("R8 below min s",  32'hCF00_0001, 1, 2'b00, 0, {32'h8000_0000, 3'b100});
    run_lit("R8 2^31 s",       32'h4F00_0000, 1, 2'b00, 0, {32'h7FFF_FFFF, 3'b100});
    run_lit("R8 max exact s",  32'h4EFF_FFFF, 1, 2'b00, 0, {32'h7FFF_FF80, 3'b000});
    run_lit("R8 -1 s",         32'hBF80_0000, 1, 2'b00, 0, {32'hFFFF_FFFF, 3'b000});
    run_lit("R9 0.25 near",    32'h3E80_0000, 1, 2'b00, 0, {32'h0, 3'b010});
    run_lit("R9 0.25 up",      32'h3E80_0000, 0, 2'b01, 0, {32'h1, 3'b010});
    run_lit("R9 -0.25 down s", 32'hBE80_0000, 1, 2'b10, 0, {32'hFFFF_FFFF, 3'b010});
    run_lit("R9 -0.25 down u", 32'hBE80_0000, 0, 2'b10, 0, {32'h0, 3'b110});
    run_lit("R9 0.25 up tz",   32'h3E80_0000, 0, 2'b01, 1, {32'h0, 3'b010});
    run_lit("R10 0.5 near",    32'h3F00_0000, 1, 2'b00, 0, {32'h0, 3'b010});
    run_lit("R10 0.75 near",   32'h3F40_0000, 1, 2'b00, 0, {32'h1, 3'b010});
    run_lit("R10 1.5 near",    32'h3FC0_0000, 0, 2'b00, 0, {32'h2, 3'b010});

    // model-driven sweep, exponents biased toward the interesting band
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] f;
      logic [7:0]  ex;
      f  = $urandom;
      ex = (i % 4 == 0) ? f[30:23] : 8'(120 + ($urandom % 42));
      if (i % 50 == 0) f[22:0] = '0;
      f[30:23] = ex;
      run("R6 sweep", f, 1'($urandom), 2'($urandom), 1'((i % 7) == 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule